// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Sub-Controller

This block gathers 32 peripheral interrupt sources into one status register and one mask register, and reduces the pending, unmasked sources to three group-summary lines for a parent interrupt controller. The three groups are audio, miscellaneous and super-I/O. It also gives the index of the lowest pending unmasked source, so that a handler can go straight to the right service routine.

Most sources are level type: their status bit follows the input. Three sources are edge type. Each of them latches on a rising input edge and holds until software clears it. Software clears an edge bit by reading the status register and writing it back with that bit at zero. A simple single-cycle bus gives access to both registers. Register offset 0x0 holds the status and offset 0x4 holds the mask.

Top module: `irq_group_ctl`

## Requirements
- R1: After reset the status and mask registers read 0, all three group outputs are low, `vec_valid` is 0 and `vec_idx` is 0.
- R2: Each level bit (every bit except 16, 22 and 28) of status equals the value its source input had at the previous rising clock edge.
- R3: Edge bits 16, 22 and 28 set one cycle after their input rises, and stay set after the input falls.
- R4: Writing offset 0x0 with an edge bit at 0 clears that edge bit on the next cycle. Writing it at 1 leaves the bit as it was.
- R5: When a rising edge and a clearing write reach the same edge bit in the same cycle, the bit ends up set.
- R6: Writes to offset 0x0 have no effect on level bits of status.
- R7: The mask register is written at offset 0x4 with all 32 bits. It keeps its value in every cycle without such a write.
- R8: `grp_audio` is high exactly when some bit in 0–7 is set in both status and mask. `grp_misc` does the same for bits 8–15, and `grp_sio` for bits 16–31.
- R9: `vec_valid` is high when any bit is set in status AND mask. `vec_idx` is then the lowest such bit number. When none is set, `vec_idx` is 0.
- R10: `bus_rdata` shows status when `bus_addr` is 0x0, the mask when it is 0x4, and zero for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Raw interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| grp_audio | output | 1 | Audio group summary |
| grp_misc | output | 1 | Miscellaneous group summary |
| grp_sio | output | 1 | Super-I/O group summary |
| vec_valid | output | 1 | Some source is pending and unmasked |
| vec_idx | output | 5 | Lowest pending unmasked source index |

## Verification
The bench walks a single source through every bit position and checks the resulting status, group line and vector. This catches a group boundary that is off by one, a wrong bit tagged as edge type, and a priority encoder that picks the highest bit instead of the lowest. It lines up a rising edge with a clearing write on the same bit. A design that lets the clear win here would silently lose an interrupt. It also writes zeros over active level bits. A design that stores those writes would drop live level requests until the next sample. Mask sweeps, and pseudo-random source and mask patterns compared against an arithmetic model, cover the vector across every lowest-bit position.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;
  localparam int MAXW = 64;

  // Index of the lowest set bit, 0 when the vector is empty
  function automatic int lowest_set(input logic [MAXW-1:0] v);
    int idx;
    idx = 0;
    for (int i = MAXW-1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  function automatic bit in_range(input int i, input int lo, input int hi);
    return (i >= lo) && (i <= hi);
  endfunction
endpackage

// File: rtl/irqgrp_src_cell.sv
module irqgrp_src_cell #(
  parameter bit IS_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic clr_req,
  output logic stat
);
  generate
    if (IS_EDGE) begin : g_edge
      logic prev_q;
      logic rise;
      assign rise = src & ~prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          stat   <= 1'b0;
        end else begin
          prev_q <= src;
          if (rise)         stat <= 1'b1;
          else if (clr_req) stat <= 1'b0;
        end
      end

      assert_edge_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> stat);
      assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !clr_req) |=> stat);
      assert_edge_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !rise) |=> !stat);
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= src;
      end
      logic unused_clr;
      assign unused_clr = clr_req;

      assert_level_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat == $past(src)));
    end
  endgenerate
endmodule

// File: rtl/irqgrp_reduce.sv
module irqgrp_reduce #(
  parameter int NSRC    = 32,
  parameter int MISC_LO = 8,
  parameter int SIO_LO  = 16,
  localparam int IDX_W  = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  output logic             grp_audio,
  output logic             grp_misc,
  output logic             grp_sio,
  output logic             vec_valid,
  output logic [IDX_W-1:0] vec_idx
);
  import irqgrp_pkg::*;

  always_comb begin
    grp_audio = 1'b0;
    grp_misc  = 1'b0;
    grp_sio   = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (in_range(i, 0, MISC_LO-1))      grp_audio = grp_audio | pend[i];
      if (in_range(i, MISC_LO, SIO_LO-1)) grp_misc  = grp_misc  | pend[i];
      if (in_range(i, SIO_LO, NSRC-1))    grp_sio   = grp_sio   | pend[i];
    end
  end

  assign vec_valid = |pend;
  assign vec_idx   = IDX_W'(lowest_set(MAXW'(pend)));

  logic [NSRC-1:0] below_idx;
  assign below_idx = (NSRC'(1) << vec_idx) - NSRC'(1);

  assert_vec_points_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> pend[vec_idx]);
  assert_vec_is_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ((pend & below_idx) == '0));
  assert_group_matches_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == (grp_audio | grp_misc | grp_sio));
endmodule

// File: rtl/irq_group_ctl.sv
module irq_group_ctl #(
  parameter int              NSRC     = 32,
  parameter int              ADDR_W   = 4,
  parameter int              MISC_LO  = 8,
  parameter int              SIO_LO   = 16,
  parameter logic [NSRC-1:0] EDGE_MAP = 32'h1041_0000,
  parameter logic [ADDR_W-1:0] STAT_OFF = 4'h0,
  parameter logic [ADDR_W-1:0] MASK_OFF = 4'h4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              grp_audio,
  output logic              grp_misc,
  output logic              grp_sio,
  output logic              vec_valid,
  output logic [IDX_W-1:0]  vec_idx
);
  logic            stat_wr;
  logic            mask_wr;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend;

  assign stat_wr = bus_wr && (bus_addr == STAT_OFF);
  assign mask_wr = bus_wr && (bus_addr == MASK_OFF);
  assign clr_vec = stat_wr ? ~bus_wdata : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irqgrp_src_cell #(.IS_EDGE(EDGE_MAP[i])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_in[i]),
      .clr_req (clr_vec[i]),
      .stat    (stat_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= bus_wdata;
  end

  assign pend = stat_q & mask_q;

  always_comb begin
    if (bus_addr == STAT_OFF)      bus_rdata = stat_q;
    else if (bus_addr == MASK_OFF) bus_rdata = mask_q;
    else                           bus_rdata = '0;
  end

  irqgrp_reduce #(.NSRC(NSRC), .MISC_LO(MISC_LO), .SIO_LO(SIO_LO)) u_reduce (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .grp_audio (grp_audio),
    .grp_misc  (grp_misc),
    .grp_sio   (grp_sio),
    .vec_valid (vec_valid),
    .vec_idx   (vec_idx)
  );

  assert_mask_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));
  assert_mask_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(bus_wdata)));
  assert_level_ignores_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_q & ~EDGE_MAP) == ($past(src_in) & ~EDGE_MAP)));
endmodule

// File: tb/sim_irq_group_ctl.sv
`timescale 1ns/1ps
module sim_irq_group_ctl;
  localparam logic [31:0] EDGES = 32'h1041_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        grp_audio, grp_misc, grp_sio, vec_valid;
  logic [4:0]  vec_idx;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_stat = '0, m_mask = '0, m_prev = '0;

  always #4 clk = ~clk;

  irq_group_ctl u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .grp_audio(grp_audio), .grp_misc(grp_misc), .grp_sio(grp_sio),
    .vec_valid(vec_valid), .vec_idx(vec_idx)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int low_bit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  // Check outputs against model: groups R8, vector R9, read data R10 / tag
  task automatic compare(input string tag);
    logic [31:0] p;
    p = m_stat & m_mask;
    check("R8 audio", {31'b0, grp_audio}, {31'b0, |p[7:0]});
    check("R8 misc",  {31'b0, grp_misc},  {31'b0, |p[15:8]});
    check("R8 sio",   {31'b0, grp_sio},   {31'b0, |p[31:16]});
    check("R9 valid", {31'b0, vec_valid}, {31'b0, |p});
    check("R9 idx",   {27'b0, vec_idx},   32'(low_bit(p)));
    if (bus_addr == 4'h0)      check(tag, bus_rdata, m_stat);
    else if (bus_addr == 4'h4) check(tag, bus_rdata, m_mask);
    else                       check("R10 other", bus_rdata, 32'h0);
  endtask

  // One clock: apply inputs, advance, update model, compare
  task automatic cyc(input string tag, input logic [31:0] s, input logic wr,
                     input logic [3:0] a, input logic [31:0] d);
    logic [31:0] rise, clr, nxt;
    src_in = s; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    rise = s & ~m_prev;
    clr  = (wr && a == 4'h0) ? (~d & EDGES) : 32'h0;
    nxt  = rise | (m_stat & ~clr);
    m_stat = (nxt & EDGES) | (s & ~EDGES);
    if (wr && a == 4'h4) m_mask = d;
    m_prev = s;
    bus_wr = 1'b0;
    compare(tag);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    // R1: reset state
    bus_addr = 4'h0; #1;
    check("R1 status", bus_rdata, 32'h0);
    bus_addr = 4'h4; #1;
    check("R1 mask", bus_rdata, 32'h0);
    check("R1 outputs", {26'b0, grp_audio, grp_misc, grp_sio, vec_valid, 2'b0},
          32'h0);
    check("R1 idx", {27'b0, vec_idx}, 32'h0);

    // R7: mask load and hold, masked sources give no groups
    cyc("R2 masked", 32'hFFFF_FFFF, 1'b0, 4'h0, 0);
    cyc("R7 hold", 32'h0, 1'b0, 4'h4, 0);
    cyc("R7 load", 32'h0, 1'b1, 4'h4, 32'hFFFF_FFFF);
    cyc("R10 read", 32'h0, 1'b0, 4'h8, 0);
    // clear edges caught during the all-ones pulse
    cyc("R4 clr", 32'h0, 1'b1, 4'h0, 32'h0);

    // Walk one source across all positions (R2, R3, R4, R8, R9)
    for (int i = 0; i < 32; i++) begin
      cyc(EDGES[i] ? "R3 rise" : "R2 level hi", 32'h1 << i, 1'b0, 4'h0, 0);
      cyc(EDGES[i] ? "R3 held" : "R2 level hi", 32'h1 << i, 1'b0, 4'h0, 0);
      cyc(EDGES[i] ? "R3 after fall" : "R2 level lo", 32'h0, 1'b0, 4'h0, 0);
      cyc("R4 keep on one", 32'h0, 1'b1, 4'h0, 32'hFFFF_FFFF);
      cyc("R4 clear zero", 32'h0, 1'b1, 4'h0, ~(32'h1 << i));
    end

    // R5: rise together with clearing write on each edge bit
    for (int i = 0; i < 32; i++) begin
      if (EDGES[i]) begin
        cyc("R5 rise vs clr", 32'h1 << i, 1'b1, 4'h0, 32'h0);
        cyc("R5 hi clr", 32'h1 << i, 1'b1, 4'h0, 32'h0);
        cyc("R5 idle", 32'h0, 1'b0, 4'h0, 0);
      end
    end

    // R6: zero writes over active level bits have no effect
    cyc("R6 drive", 32'h5A5A_A5A5, 1'b0, 4'h0, 0);
    cyc("R6 zero write", 32'h5A5A_A5A5, 1'b1, 4'h0, 32'h0);
    cyc("R6 ones write", 32'h0000_0000, 1'b1, 4'h0, 32'hFFFF_FFFF);
    cyc("R6 clean", 32'h0, 1'b1, 4'h0, 32'h0);

    // R9: mask sweeps with all level sources high
    for (int i = 0; i < 32; i++) begin
      cyc("R7 single", 32'hEFBE_FFFF, 1'b1, 4'h4, 32'h1 << i);
      cyc("R9 upper", 32'hEFBE_FFFF, 1'b1, 4'h4, ~((32'h1 << i) - 1));
    end

    // Pseudo-random patterns for vector and groups
    lf = 32'hACE1_2468;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cyc("R7 rnd mask", lf & {lf[15:0], lf[31:16]}, 1'b1, 4'h4, lf ^ 32'h0F0F_3C3C);
      cyc("R9 rnd", lf >> (k % 32), 1'b0, 4'h0, 0);
      cyc("R4 rnd clr", lf, 1'b1, 4'h0, lf << 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule